// File: doc/BRIEF.md
# Linked-List Receive DMA Engine

This block takes received network frames one byte at a time and stores them in system memory. It finds its target buffers by walking a list of descriptors that software builds in memory. Each descriptor is four 32-bit words, read one after another from the descriptor address. Word 0 carries status and a hand-off bit: when bit 31 is set, the engine may use the descriptor. Word 1 carries the buffer byte count in bits 11:0, a follow-the-link flag in bit 14 and a wrap-to-base flag in bit 15. Word 2 is the word-aligned buffer address and word 3 is a link address.

Software starts the engine through a small write-only register port. Address 0 sets the list base, bit 0 at address 1 sets the run bit, and any write to address 2 asks the engine to look at the list again. The engine fills each buffer with frame bytes. A frame that is too long for one buffer continues in the next descriptor. When a buffer is finished, the engine writes word 0 back with the hand-off bit cleared, which returns the descriptor to software. If the engine fetches a descriptor it does not hold, it parks in a suspended state until software asks it to look again. A 3-bit state output shows what the receive process is doing.

Top module: `rxdma_engine`

## Requirements
- R1: After reset the state output reads 0 (stopped), no memory request is raised, and frame input is accepted and discarded.
- R2: Once the run bit is set, the engine reads the four descriptor words at the programmed base address, lowest address first. If word 0 bit 31 is set, it enters the waiting state (3).
- R3: If the fetched word 0 has bit 31 clear, the engine enters state 4 and issues no memory request. A write to register address 2 while in state 4 makes it fetch the same descriptor again.
- R4: At most the number of bytes in word 1 bits 11:0 go into a buffer. The rest of the frame goes into the next descriptor. A descriptor closed before the frame ends has bit 9 set only if the frame began in it, bit 8 clear, and bits 29:16 holding the frame bytes stored so far.
- R5: After closing a descriptor, the next one is taken from the base register when word 1 bit 15 is set. Otherwise it is taken from word 3 when bit 14 is set. Otherwise it is the current descriptor address plus 16.
- R6: The close writes word 0 with bit 31 clear, as a full-word write. It is issued only after every data write into that buffer has been granted.
- R7: The state output uses 0 stopped, 1 fetching, 3 waiting for a frame, 4 suspended, 5 closing and 7 moving data. No other value appears.
- R8: The descriptor holding the final byte of a frame is closed with bit 8 set and the full frame length in bits 29:16. Bit 15 is set in that descriptor if the final byte carried the error flag.
- R9: Bytes that arrive while stopped or suspended, and the remainder of a frame cut off that way, are consumed and never written to memory.
- R10: Bytes are packed little-endian into 32-bit words (byte k of the buffer goes to lane k mod 4). A partly filled word is written with only its filled byte enables set.
- R11: Writing 0 to the run bit returns the state to 0 and withdraws any pending memory request.
- R12: Read and write requests are never raised together. A raised request keeps its address and data until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the final byte of its frame |
| in_err | input | 1 | Frame had a receive error (sampled with in_last) |
| in_ready | output | 1 | Byte is taken on this edge when in_valid is high |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Read byte address (word-aligned) |
| mem_rd_gnt | input | 1 | Read granted, data valid this cycle |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Write byte address (word-aligned) |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Byte enables, bit k for bits 8k+7:8k |
| mem_wr_gnt | input | 1 | Write granted |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 control, 2 poll |
| reg_wdata | input | 32 | Register write data |
| rx_state | output | 3 | Receive process state |

## Verification
The list uses one linked descriptor, one contiguous descriptor and one wrapping descriptor. Because close addresses come from three different rules, a wrong next-address choice shows up as a close at the wrong place. An 8-byte frame fills its buffer exactly, which tells the frame-end and buffer-full paths apart. A 10-byte frame split 6+4 exercises buffer overflow into the next descriptor and the partial byte enables. A frame sent while suspended must leave memory untouched. A short frame with the error flag, sent after re-arming and polling, must overwrite only three lanes and set the error bit. All memory grants stall in an irregular pattern, so request holding and write ordering are exercised under back-pressure.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    RS_STOP  = 3'd0,
    RS_FETCH = 3'd1,
    RS_WAIT  = 3'd3,
    RS_SUSP  = 3'd4,
    RS_CLOSE = 3'd5,
    RS_XFER  = 3'd7
  } rx_state_e;

  localparam int OWN_BIT   = 31;
  localparam int ERR_BIT   = 15;
  localparam int FIRST_BIT = 9;
  localparam int LAST_BIT  = 8;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 14;
  localparam int SIZE_W    = 12;
  localparam int LINK_BIT  = 14;
  localparam int WRAP_BIT  = 15;
  localparam int LANES     = 4;

  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_POLL = 2'd2;

  function automatic logic [31:0] close_word(input logic first, input logic last,
                                             input logic err, input logic [LEN_W-1:0] len);
    logic [31:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[ERR_BIT]   = err;
    w[FIRST_BIT] = first;
    w[LAST_BIT]  = last;
    return w;
  endfunction
endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic              run_q,
  output logic              poll_p
);
  import rxdma_pkg::*;

  logic              base_en, ctrl_en;
  logic [ADDR_W-1:0] base_n;
  logic              run_n;

  assign base_en = reg_we && (reg_addr == REG_BASE);
  assign ctrl_en = reg_we && (reg_addr == REG_CTRL);
  assign poll_p  = reg_we && (reg_addr == REG_POLL);

  always_comb begin
    base_n = base_q;
    run_n  = run_q;
    if (base_en) base_n = reg_wdata[ADDR_W-1:0];
    if (ctrl_en) run_n  = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      run_q  <= 1'b0;
    end else begin
      base_q <= base_n;
      run_q  <= run_n;
    end
  end
endmodule

// File: rtl/rxdma_pack.sv
module rxdma_pack #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc,
  input  logic [7:0]        acc_byte,
  input  logic [1:0]        acc_lane,
  input  logic              acc_flush,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              gnt,
  output logic              pend_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [31:0]       data_q,
  output logic [3:0]        be_q
);
  import rxdma_pkg::*;

  logic              pend_n;
  logic [ADDR_W-1:0] addr_n;
  logic              drain;

  assign drain = pend_q && gnt;

  // One byte register and enable per lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       hit;
    logic [7:0] byte_n;
    logic       en_n;
    assign hit = acc && (acc_lane == 2'(l));

    always_comb begin
      byte_n = hit ? acc_byte : data_q[8*l +: 8];
      if (clr || drain) en_n = 1'b0;
      else if (hit)     en_n = 1'b1;
      else              en_n = be_q[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[8*l +: 8] <= '0;
        be_q[l]          <= 1'b0;
      end else begin
        data_q[8*l +: 8] <= byte_n;
        be_q[l]          <= en_n;
      end
    end
  end

  always_comb begin
    pend_n = pend_q;
    addr_n = addr_q;
    if (clr) begin
      pend_n = 1'b0;
    end else begin
      if (drain) pend_n = 1'b0;
      if (acc) begin
        addr_n = acc_addr;
        if (acc_flush) pend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= pend_n;
      addr_q <= addr_n;
    end
  end
endmodule

// File: rtl/rxdma_fsm.sv
module rxdma_fsm #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_q,
  input  logic              poll_p,
  input  logic [ADDR_W-1:0] base_q,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_ready,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_gnt,
  input  logic [31:0]       rd_data,
  input  logic              pk_pend,
  input  logic              wr_gnt,
  output logic              acc,
  output logic [7:0]        acc_byte,
  output logic [1:0]        acc_lane,
  output logic              acc_flush,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              cl_req,
  output logic [ADDR_W-1:0] cl_addr,
  output logic [31:0]       cl_data,
  output logic              clr,
  output logic [2:0]        state
);
  import rxdma_pkg::*;

  localparam logic [ADDR_W-1:0] DESC_BYTES = ADDR_W'(16);

  rx_state_e         state_q, state_n;
  logic [ADDR_W-1:0] desc_q, desc_n, bufa_q, bufa_n, link_q, link_n;
  logic [1:0]        widx_q, widx_n;
  logic              own_q, own_n, link_en_q, link_en_n, wrap_q, wrap_n;
  logic [SIZE_W-1:0] size_q, size_n, bcnt_q, bcnt_n;
  logic [LEN_W-1:0]  flen_q, flen_n;
  logic              infr_q, infr_n, first_q, first_n, done_q, done_n;
  logic              err_q, err_n, drop_q, drop_n;
  logic              discard, room, can_store, take, store;

  assign discard   = drop_q || (state_q == RS_STOP) || (state_q == RS_SUSP);
  assign room      = (bcnt_q != size_q);
  assign can_store = run_q && ((state_q == RS_WAIT) || (state_q == RS_XFER))
                     && !pk_pend && !done_q && room;
  assign in_ready  = discard || can_store;
  assign take      = in_valid && in_ready;
  assign store     = take && !discard;

  assign acc       = store;
  assign acc_byte  = in_data;
  assign acc_lane  = bcnt_q[1:0];
  assign acc_flush = in_last || (bcnt_q[1:0] == 2'd3) || ((bcnt_q + SIZE_W'(1)) == size_q);
  assign acc_addr  = bufa_q + ADDR_W'({bcnt_q[SIZE_W-1:2], 2'b00});

  assign rd_addr   = desc_q + ADDR_W'({widx_q, 2'b00});
  assign cl_addr   = desc_q;
  assign cl_data   = close_word(first_q, done_q, done_q && err_q, flen_q);
  assign clr       = !run_q;
  assign state     = state_q;

  always_comb begin
    state_n = state_q;  desc_n = desc_q;  widx_n = widx_q;   own_n = own_q;
    size_n = size_q;    link_en_n = link_en_q;  wrap_n = wrap_q;
    bufa_n = bufa_q;    link_n = link_q;  bcnt_n = bcnt_q;   flen_n = flen_q;
    infr_n = infr_q;    first_n = first_q; done_n = done_q;  err_n = err_q;
    drop_n = drop_q;
    rd_req = 1'b0;
    cl_req = 1'b0;

    if (store) begin
      bcnt_n = bcnt_q + SIZE_W'(1);
      flen_n = infr_q ? flen_q + LEN_W'(1) : LEN_W'(1);
      if (!infr_q) first_n = 1'b1;
      infr_n = 1'b1;
      if (in_last) begin
        done_n = 1'b1;
        err_n  = in_err;
      end
    end

    if (!run_q) begin
      state_n = RS_STOP;
      infr_n  = 1'b0;
      done_n  = 1'b0;
      if (infr_q) drop_n = 1'b1;
    end else begin
      unique case (state_q)
        RS_STOP: begin
          state_n = RS_FETCH;
          desc_n  = base_q;
          widx_n  = '0;
        end
        RS_FETCH: begin
          rd_req = 1'b1;
          if (rd_gnt) begin
            widx_n = widx_q + 2'd1;
            unique case (widx_q)
              2'd0: own_n = rd_data[OWN_BIT];
              2'd1: begin
                size_n    = rd_data[SIZE_W-1:0];
                link_en_n = rd_data[LINK_BIT];
                wrap_n    = rd_data[WRAP_BIT];
              end
              2'd2: bufa_n = rd_data[ADDR_W-1:0];
              default: begin
                link_n = rd_data[ADDR_W-1:0];
                if (own_q) begin
                  state_n = infr_q ? RS_XFER : RS_WAIT;
                  bcnt_n  = '0;
                  first_n = 1'b0;
                  done_n  = 1'b0;
                end else begin
                  state_n = RS_SUSP;
                  if (infr_q) drop_n = 1'b1;
                  infr_n = 1'b0;
                end
              end
            endcase
          end
        end
        RS_WAIT: if (store) state_n = RS_XFER;
        RS_XFER: if (!pk_pend && !store && (done_q || !room)) state_n = RS_CLOSE;
        RS_CLOSE: begin
          cl_req = 1'b1;
          if (wr_gnt) begin
            state_n = RS_FETCH;
            widx_n  = '0;
            if (wrap_q)         desc_n = base_q;
            else if (link_en_q) desc_n = link_q;
            else                desc_n = desc_q + DESC_BYTES;
            if (done_q) infr_n = 1'b0;
          end
        end
        RS_SUSP: if (poll_p) begin
          state_n = RS_FETCH;
          widx_n  = '0;
        end
        default: state_n = RS_STOP;
      endcase
    end

    if (take && discard) drop_n = !in_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_STOP; desc_q <= '0; widx_q <= '0; own_q <= 1'b0;
      size_q <= '0; link_en_q <= 1'b0; wrap_q <= 1'b0; bufa_q <= '0;
      link_q <= '0; bcnt_q <= '0; flen_q <= '0; infr_q <= 1'b0;
      first_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; drop_q <= 1'b0;
    end else begin
      state_q <= state_n; desc_q <= desc_n; widx_q <= widx_n; own_q <= own_n;
      size_q <= size_n; link_en_q <= link_en_n; wrap_q <= wrap_n; bufa_q <= bufa_n;
      link_q <= link_n; bcnt_q <= bcnt_n; flen_q <= flen_n; infr_q <= infr_n;
      first_q <= first_n; done_q <= done_n; err_q <= err_n; drop_q <= drop_n;
    end
  end
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_ready,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_gnt,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic [3:0]        mem_wr_be,
  input  logic              mem_wr_gnt,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [2:0]        rx_state
);
  logic [1:0]        rs_q;
  logic              rst_l;
  logic [ADDR_W-1:0] base_q;
  logic              run_on, poll_p, clr;
  logic              acc, acc_flush, pk_pend, cl_req, pk_gnt;
  logic [7:0]        acc_byte;
  logic [1:0]        acc_lane;
  logic [ADDR_W-1:0] acc_addr, pk_addr, cl_addr;
  logic [31:0]       pk_data, cl_data;
  logic [3:0]        pk_be;

  // Asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  rxdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_l), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .base_q(base_q), .run_q(run_on), .poll_p(poll_p)
  );

  rxdma_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_l), .run_q(run_on), .poll_p(poll_p), .base_q(base_q),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .rd_req(mem_rd_req), .rd_addr(mem_rd_addr),
    .rd_gnt(mem_rd_gnt), .rd_data(mem_rd_data), .pk_pend(pk_pend),
    .wr_gnt(mem_wr_gnt), .acc(acc), .acc_byte(acc_byte), .acc_lane(acc_lane),
    .acc_flush(acc_flush), .acc_addr(acc_addr), .cl_req(cl_req),
    .cl_addr(cl_addr), .cl_data(cl_data), .clr(clr), .state(rx_state)
  );

  assign pk_gnt = mem_wr_gnt && !cl_req;

  rxdma_pack #(.ADDR_W(ADDR_W)) u_pack (
    .clk(clk), .rst_n(rst_l), .clr(clr), .acc(acc), .acc_byte(acc_byte),
    .acc_lane(acc_lane), .acc_flush(acc_flush), .acc_addr(acc_addr),
    .gnt(pk_gnt), .pend_q(pk_pend), .addr_q(pk_addr), .data_q(pk_data),
    .be_q(pk_be)
  );

  assign mem_wr_req  = pk_pend || cl_req;
  assign mem_wr_addr = cl_req ? cl_addr : pk_addr;
  assign mem_wr_data = cl_req ? cl_data : pk_data;
  assign mem_wr_be   = cl_req ? 4'hF    : pk_be;
endmodule

// File: rtl/rxdma_chk.sv
module rxdma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        rx_state,
  input logic              in_ready,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_gnt,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [31:0]       mem_wr_data,
  input logic              mem_wr_gnt,
  input logic              pk_pend,
  input logic              cl_req,
  input logic              run_on
);
  // R7
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_state == 3'd0 || rx_state == 3'd1 || rx_state == 3'd3 ||
    rx_state == 3'd4 || rx_state == 3'd5 || rx_state == 3'd7);

  // R12
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_gnt && run_on |=>
      mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_gnt && run_on |=> mem_rd_req && $stable(mem_rd_addr));

  // R3
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_state == 3'd4 |-> !mem_rd_req && !mem_wr_req);

  // R3
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_state == 3'd4) |-> $past(rx_state) == 3'd1);

  // R9
  idle_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 3'd0 || rx_state == 3'd4) |-> in_ready);

  // R6
  close_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pk_pend, cl_req}));

  // R11
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_on |=> rx_state == 3'd0 && !mem_rd_req && !cl_req);
endmodule

bind rxdma_engine rxdma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_state(rx_state), .in_ready(in_ready),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_gnt(mem_rd_gnt),
  .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .mem_wr_gnt(mem_wr_gnt), .pk_pend(pk_pend), .cl_req(cl_req), .run_on(run_on)
);

// File: tb/test_rxdma_engine.sv
module test_rxdma_engine;
  logic        clk, rst_n;
  logic        in_valid, in_last, in_err, in_ready;
  logic [7:0]  in_data;
  logic        mem_rd_req, mem_rd_gnt, mem_wr_req, mem_wr_gnt;
  logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
  logic [3:0]  mem_wr_be;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [2:0]  rx_state;

  int checks = 0, failures = 0, overlap = 0;
  logic [31:0] mem [int unsigned];
  logic [7:0]  lfsr;
  logic        rd_ok, wr_ok;

  typedef struct {
    logic [31:0] da, dv, ba, bv;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  rxdma_engine i_rxdma_engine (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  // Memory model: irregular grants, reads presented at the falling edge
  always @(negedge clk) begin
    if (!rst_n) lfsr <= 8'h5A;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ok       <= lfsr[0] | lfsr[2];
    wr_ok       <= lfsr[1] | lfsr[3];
    mem_rd_data <= mrd(mem_rd_addr);
  end
  assign mem_rd_gnt = mem_rd_req & rd_ok;
  assign mem_wr_gnt = mem_wr_req & wr_ok;

  // Monitor: pops expected closes and applies writes
  always @(posedge clk) begin
    if (rst_n && mem_rd_req && mem_wr_req) overlap++;
    if (rst_n && mem_wr_req && mem_wr_gnt) begin
      if (mem_wr_addr == 32'h1000 || mem_wr_addr == 32'h1200 || mem_wr_addr == 32'h1210) begin
        if (q.size() == 0) chk(1'b0, "R9 unexpected close", mem_wr_addr, 32'h0);
        else begin
          cur = q.pop_front();
          chk(mem_wr_addr == cur.da, {cur.tag, " R5 close address"}, mem_wr_addr, cur.da);
          chk(mem_wr_data == cur.dv && mem_wr_be == 4'hF, {cur.tag, " status word"}, mem_wr_data, cur.dv);
          chk(mrd(cur.ba) == cur.bv, {cur.tag, " R6 R10 data before close"}, mrd(cur.ba), cur.bv);
        end
      end
      begin
        logic [31:0] w;
        w = mrd(mem_wr_addr);
        for (int b = 0; b < 4; b++)
          if (mem_wr_be[b]) w[8*b +: 8] = mem_wr_data[8*b +: 8];
        mem[mem_wr_addr >> 2] = w;
      end
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit last, input bit err);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_err = err;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send_frame(input logic [7:0] seed, input int n, input bit err);
    for (int i = 0; i < n; i++) send_byte(seed + 8'(i), i == n - 1, err);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
  endtask

  task automatic push(input logic [31:0] da, dv, ba, bv, input string tag);
    exp_t e;
    e.da = da; e.dv = dv; e.ba = ba; e.bv = bv; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_state(input logic [2:0] s, input string tag);
    int n;
    n = 0;
    while (rx_state != s && n < 2000) begin @(negedge clk); n++; end
    chk(rx_state == s, tag, 32'(rx_state), 32'(s));
  endtask

  task automatic wait_drain(input string tag);
    int n;
    n = 0;
    while (q.size() != 0 && n < 4000) begin @(negedge clk); n++; end
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R2 watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_err = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int a = 32'h2000; a < 32'h2240; a += 4) mem[a >> 2] = 32'hAAAA_AAAA;
    // Linked, contiguous and wrapping descriptors
    mem[32'h1000 >> 2] = 32'h8000_0000; mem[32'h1004 >> 2] = 32'h0000_4008;
    mem[32'h1008 >> 2] = 32'h0000_2000; mem[32'h100C >> 2] = 32'h0000_1200;
    mem[32'h1200 >> 2] = 32'h8000_0000; mem[32'h1204 >> 2] = 32'h0000_0006;
    mem[32'h1208 >> 2] = 32'h0000_2100; mem[32'h120C >> 2] = 32'h000D_EAD0;
    mem[32'h1210 >> 2] = 32'h8000_0000; mem[32'h1214 >> 2] = 32'h0000_C010;
    mem[32'h1218 >> 2] = 32'h0000_2200; mem[32'h121C >> 2] = 32'h0000_3000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_state == 3'd0, "R1 reset state", 32'(rx_state), 0);
    chk(!mem_rd_req && !mem_wr_req, "R1 no requests", {mem_rd_req, mem_wr_req}, 0);
    chk(in_ready, "R1 R9 sink while stopped", 32'(in_ready), 1);

    reg_wr(2'd0, 32'h1000);
    reg_wr(2'd1, 32'h1);
    wait_state(3'd3, "R2 R7 waiting after start");

    // Exact buffer fill
    push(32'h1000, 32'h0008_0300, 32'h2004, 32'h1716_1514, "R8 exact fit");
    send_frame(8'h10, 8, 1'b0);
    wait_drain("R8 exact fit closed");

    // Spill across descriptors, then wrap to a held descriptor
    push(32'h1200, 32'h0006_0200, 32'h2104, 32'hAAAA_2524, "R4 spill first part");
    push(32'h1210, 32'h000A_0100, 32'h2200, 32'h2928_2726, "R8 spill last part");
    send_frame(8'h20, 10, 1'b0);
    wait_drain("R4 spill closed");
    chk(mrd(32'h2204) == 32'hAAAA_AAAA, "R4 buffer limit respected", mrd(32'h2204), 32'hAAAA_AAAA);
    wait_state(3'd4, "R3 R5 suspended after wrap");

    send_frame(8'h30, 4, 1'b0);
    repeat (5) @(negedge clk);
    chk(rx_state == 3'd4, "R9 still suspended after drop", 32'(rx_state), 4);
    chk(mrd(32'h2000) == 32'h1312_1110, "R9 dropped frame not stored", mrd(32'h2000), 32'h1312_1110);

    mem[32'h1000 >> 2] = 32'h8000_0000;
    reg_wr(2'd2, 32'h0);
    wait_state(3'd3, "R3 poll refetch");
    push(32'h1000, 32'h0003_8300, 32'h2000, 32'h1342_4140, "R8 R10 error short frame");
    send_frame(8'h40, 3, 1'b1);
    wait_drain("R8 error frame closed");
    wait_state(3'd4, "R3 suspend on released descriptor");

    reg_wr(2'd1, 32'h0);
    wait_state(3'd0, "R11 stopped");
    chk(in_ready, "R9 sink after stop", 32'(in_ready), 1);
    send_frame(8'h50, 2, 1'b0);
    repeat (5) @(negedge clk);
    chk(rx_state == 3'd0 && !mem_wr_req, "R11 stays stopped", 32'(rx_state), 0);
    chk(overlap == 0, "R12 no overlapping requests", overlap, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule